// File: doc/BRIEF.md
# QPSK Weighted-Segment Demodulator

This block turns a one-bit square-wave QPSK carrier back into the serial bit stream that produced it. It splits each carrier period into four equal segments. The first clock of every segment samples the input level. A segment that reads low adds a weight to an accumulator, and the weight depends on where the segment sits in the period. A segment that reads high adds nothing.

When the period ends, the block stores the accumulated sum. A small table decodes the sum into a dibit, and the dibit leaves the block as serial bits, most significant bit first, one bit per half period. The block shares its clock with the modulator and relies on the two being aligned to the same period boundaries. The `start` input frames a demodulation run: raising it begins the first period, and lowering it stops the run and clears the pipeline.

Timing below uses the default `SEG_CLKS = 2`, which gives segments of two clocks and a period of eight clocks. Edge 0 is the first rising clock edge at which `start` is sampled high.

Top module: `qpskd_demod`

## Requirements
- R1: Segment s of period k (s = 0..3) starts at edge 8k+2s, and `mod_in` is sampled only at that edge. Its level on the other clock of the segment has no effect on `ser_out`.
- R2: A low sample adds weight 1, 1, 2 or 3 for segment 0, 1, 2 or 3. A high sample adds 0. A period whose only low segment is segment 3 therefore sums to 3 and decodes to dibit 11.
- R3: A period sum of 5 decodes to dibit 00, a sum of 2 to dibit 10, a sum of 4 to dibit 01 and a sum of 3 to dibit 11. With segment levels written seg0..seg3 (1 = high), the carriers HHLL, LLHH, LHHL and HLLH give 00, 10, 01 and 11.
- R4: Any other sum (0, 1, 6 or 7) decodes to dibit 00.
- R5: The high bit of the dibit for period k is on `ser_out` after edge 8k+12 and the low bit after edge 8k+16. Each bit is held for four clocks.
- R6: `ser_out` is 0 after edges 0 through 11 of a run. These are three leading zero bits.
- R7: After any edge at which `start` is low, `ser_out` is 0. While `start` stays low, `mod_in` has no effect.
- R8: When `start` rises again, a new run begins with its own edge 0. Its output follows R5 and R6 with no residue from the previous run.
- R9: The synchronous active-high reset `rst` makes `ser_out` 0 after the next edge.
- R10: The accumulator starts afresh in every period, so the decoded dibit depends only on that period's samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the modulator |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | High frames a demodulation run; low idles and clears |
| mod_in | input | 1 | One-bit square-wave QPSK carrier |
| ser_out | output | 1 | Recovered serial bit stream, high bit of each dibit first |

## Verification
The assertions assume that `start` rises exactly on a carrier period boundary of the modulator, and that `rst` and `start` change only between clock edges. Under those assumptions the segment counter and the sampling points stay aligned with the carrier. The stimulus raises `start` together with the first segment level of a run and changes every input on the falling clock edge. Within a segment it holds the carrier level steady, except in one run that flips the level on the second clock of each segment to show that only the first clock is sampled.

// File: rtl/qpskd_pkg.sv
package qpskd_pkg;

    // Number of segments per carrier period (fixed by the weight scheme)
    localparam int NUM_SEGS = 4;
    // Sum of the largest weights, 1+1+2+3 = 7, fits in three bits
    localparam int SUM_W    = 3;

    typedef logic [SUM_W-1:0] sum_t;
    typedef logic [1:0]       seg_t;

    typedef enum logic [1:0] {
        DIB_00 = 2'b00,
        DIB_01 = 2'b01,
        DIB_10 = 2'b10,
        DIB_11 = 2'b11
    } dibit_e;

    // Timing strobes produced once per segment or period
    typedef struct packed {
        logic samp;   // first clock of a segment
        seg_t seg;    // segment position in the period
        logic first;  // first clock of the period
        logic half;   // first clock of segment 2
        logic last;   // last clock of the period
    } tick_t;

    // Weight added by one segment sample
    function automatic sum_t seg_weight(input seg_t s, input logic lvl);
        sum_t w;
        if (lvl) begin
            w = '0;
        end else begin
            case (s)
                2'd0:    w = sum_t'(1);
                2'd1:    w = sum_t'(1);
                2'd2:    w = sum_t'(2);
                default: w = sum_t'(3);
            endcase
        end
        return w;
    endfunction

    // Period sum to dibit
    function automatic dibit_e sum_to_dibit(input sum_t s);
        dibit_e d;
        case (s)
            sum_t'(5): d = DIB_00;
            sum_t'(2): d = DIB_10;
            sum_t'(4): d = DIB_01;
            sum_t'(3): d = DIB_11;
            default:   d = DIB_00;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/qpskd_seg_timer.sv
module qpskd_seg_timer
    import qpskd_pkg::*;
#(
    parameter int SEG_CLKS = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output tick_t tick
);

    localparam int SUB_W = (SEG_CLKS > 1) ? $clog2(SEG_CLKS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SEG_CLKS - 1);

    logic [SUB_W-1:0] sub_q;
    seg_t             seg_q;

    always_ff @(posedge clk) begin
        if (rst || !start) begin
            sub_q <= '0;
            seg_q <= '0;
        end else if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            seg_q <= seg_t'(seg_q + 2'd1);
        end else begin
            sub_q <= SUB_W'(sub_q + 1'b1);
        end
    end

    always_comb begin
        tick.samp  = start && (sub_q == '0);
        tick.seg   = seg_q;
        tick.first = start && (seg_q == 2'd0) && (sub_q == '0);
        tick.half  = start && (seg_q == 2'd2) && (sub_q == '0);
        tick.last  = start && (seg_q == 2'd3) && (sub_q == SUB_LAST);
    end

    // R1: period strobes never coincide
    p_strobes_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tick.first, tick.half, tick.last}));

    // R8: leaving idle always lands on a period start
    p_idle_to_first_r8: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!start || tick.first));

    // R1: a completed period wraps to the first segment
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (start && tick.last) |=> (!start || tick.first));

endmodule

// File: rtl/qpskd_weight_acc.sv
module qpskd_weight_acc
    import qpskd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mod_in,
    input  logic samp,
    input  seg_t seg,
    input  logic last,
    output sum_t sum_q
);

    sum_t acc_q;
    sum_t w;

    always_comb w = seg_weight(seg, mod_in);

    always_ff @(posedge clk) begin
        if (rst || !start) begin
            acc_q <= '0;
            sum_q <= '0;
        end else begin
            if (samp) begin
                acc_q <= (seg == 2'd0) ? w : sum_t'(acc_q + w);
            end
            if (last) begin
                sum_q <= samp ? sum_t'(acc_q + w) : acc_q;
            end
        end
    end

    // R10: a high first segment leaves the accumulator empty
    p_acc_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (start && samp && seg == 2'd0 && mod_in) |=> (acc_q == '0));

    // R2: a high sample in a later segment adds nothing
    p_high_no_add_r2: assert property (@(posedge clk) disable iff (rst)
        (start && samp && seg != 2'd0 && mod_in) |=> (acc_q == $past(acc_q)));

endmodule

// File: rtl/qpskd_dibit_ser.sv
module qpskd_dibit_ser
    import qpskd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  sum_t sum_q,
    input  logic first,
    input  logic half,
    output logic ser_out
);

    logic [1:0] dibit_q;

    always_ff @(posedge clk) begin
        if (rst || !start) begin
            dibit_q <= '0;
            ser_out <= 1'b0;
        end else begin
            if (first) begin
                dibit_q <= sum_to_dibit(sum_q);
                ser_out <= dibit_q[0];
            end
            if (half) begin
                ser_out <= dibit_q[1];
            end
        end
    end

    // R5: output only moves on a half-period boundary
    p_ser_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !first && !half) |=> $stable(ser_out));

    // R7: idle forces the output low
    p_idle_out_r7: assert property (@(posedge clk) disable iff (rst)
        !start |=> !ser_out);

endmodule

// File: rtl/qpskd_demod.sv
module qpskd_demod
    import qpskd_pkg::*;
#(
    parameter int SEG_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mod_in,
    output logic ser_out
);

    tick_t tick;
    sum_t  sum_q;

    qpskd_seg_timer #(.SEG_CLKS(SEG_CLKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tick  (tick)
    );

    qpskd_weight_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .mod_in (mod_in),
        .samp   (tick.samp),
        .seg    (tick.seg),
        .last   (tick.last),
        .sum_q  (sum_q)
    );

    qpskd_dibit_ser u_ser (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .sum_q   (sum_q),
        .first   (tick.first),
        .half    (tick.half),
        .ser_out (ser_out)
    );

    // R9: reset clears the output on the next edge
    p_reset_out_r9: assert property (@(posedge clk)
        rst |=> !ser_out);

endmodule

// File: tb/tb_qpskd_demod.sv
module tb_qpskd_demod;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic mod_in = 1'b1;
    logic ser_out;

    int pass_cnt = 0;
    int fail_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    qpskd_demod dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mod_in  (mod_in),
        .ser_out (ser_out)
    );

    // [5:2] segment levels (bit 2 = segment 0, 1 = high), [1:0] expected dibit
    localparam int NVEC = 8;
    localparam logic [5:0] VEC [NVEC] = '{
        {4'b0011, 2'b00},   // HHLL sum 5
        {4'b1100, 2'b10},   // LLHH sum 2
        {4'b0000, 2'b00},   // all low sum 7
        {4'b0110, 2'b01},   // LHHL sum 4
        {4'b1111, 2'b00},   // all high sum 0
        {4'b1001, 2'b11},   // HLLH sum 3
        {4'b1110, 2'b00},   // seg0 low only, sum 1
        {4'b0111, 2'b11}    // seg3 low only, sum 3
    };

    function automatic string vtag(input int i);
        case (i)
            2, 4, 6: return "R4 R5 R10";
            7:       return "R2 R5";
            default: return "R3 R5 R10";
        endcase
    endfunction

    task automatic check(input logic got, input logic exp, input string req, input string what);
        if (got === exp) begin
            pass_cnt++;
        end else begin
            fail_cnt++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // Idle, then one run of two periods followed by all-high periods.
    task automatic short_run(input logic [3:0] p0, input logic [3:0] p1,
                             input logic [1:0] e0, input logic [1:0] e1,
                             input bit glitch, input string req);
        logic [1:0] ex [2];
        ex[0] = e0;
        ex[1] = e1;
        @(negedge clk);
        start = 1'b1;
        for (int n = 0; n < 28; n++) begin
            int k;
            int s;
            logic lvl;
            k = n / 8;
            s = (n % 8) / 2;
            lvl = (k == 0) ? p0[s] : (k == 1) ? p1[s] : 1'b1;
            mod_in = (glitch && (n % 2 == 1)) ? ~lvl : lvl;
            @(posedge clk);
            #2;
            if (n == 8) check(ser_out, 1'b0, {req, " R6"}, "leading zero");
            if (n >= 12 && (n % 4) == 0) begin
                int b;
                b = (n - 12) / 4;
                check(ser_out, b[0] ? ex[b / 2][0] : ex[b / 2][1], req, $sformatf("bit %0d", b));
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            fail_cnt++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #2;
        check(ser_out, 1'b0, "R9", "reset state");
        @(negedge clk);
        rst = 1'b0;

        // Vector table walked as one continuous run
        start = 1'b1;
        for (int n = 0; n < 8 * NVEC + 16; n++) begin
            int k;
            int s;
            k = n / 8;
            s = (n % 8) / 2;
            mod_in = (k < NVEC) ? VEC[k][2 + s] : 1'b1;
            @(posedge clk);
            #2;
            if ((n % 4) == 0) begin
                if (n < 12) begin
                    check(ser_out, 1'b0, "R6", $sformatf("leading zero after edge %0d", n));
                end else begin
                    int b;
                    int kk;
                    b = (n - 12) / 4;
                    kk = b / 2;
                    if (kk < NVEC)
                        check(ser_out, b[0] ? VEC[kk][0] : VEC[kk][1], vtag(kk),
                              $sformatf("period %0d bit %0d", kk, b[0] ? 0 : 1));
                end
            end
            @(negedge clk);
        end

        // R7: start low clears and ignores mod_in
        begin
            bit bad;
            bad = 1'b0;
            start = 1'b0;
            @(posedge clk);
            #2;
            check(ser_out, 1'b0, "R7", "output after start falls");
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                mod_in = i[0];
                @(posedge clk);
                #2;
                if (ser_out !== 1'b0) bad = 1'b1;
            end
            check(bad, 1'b0, "R7", "output while idle with toggling input");
        end

        // R8: restart aligns a fresh run
        short_run(4'b1100, 4'b1001, 2'b10, 2'b11, 1'b0, "R8 R5");
        start = 1'b0;
        repeat (3) @(negedge clk);

        // R1: second clock of each segment is not sampled
        short_run(4'b0110, 4'b1001, 2'b01, 2'b11, 1'b1, "R1");
        start = 1'b0;
        repeat (3) @(negedge clk);

        // R9: reset in mid run while output is high
        start = 1'b1;
        for (int n = 0; n < 14; n++) begin
            mod_in = VEC[1][2 + (n % 8) / 2];
            @(posedge clk);
            @(negedge clk);
        end
        check(ser_out, 1'b1, "R9 R5", "output high before reset");
        rst = 1'b1;
        @(posedge clk);
        #2;
        check(ser_out, 1'b0, "R9", "output after mid-run reset");
        @(negedge clk);
        rst = 1'b0;
        start = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

endmodule